// File: doc/BRIEF.md
# LCD panel timing generator

This block produces the horizontal and vertical timing for a parallel LCD panel. It drives a line sync, a frame sync and a display-enable strobe, and it exposes the current pixel and line counts. It can also raise a one-cycle pulse at the start of every frame. The counters step only on cycles where the pixel-clock enable input is high, so the clock divider stays outside the block.

Software sets the timing through a 16-bit register-write port. Horizontal quantities are coded in units of 8 pixels and every count is stored minus one. The five timing registers are shadow copies. Their values reach the counters only at a frame boundary, or at any time while the display is off. One frame therefore never mixes two sets of parameters.

The control register takes effect on the clock after it is written. It holds the display-on bit, the two sync polarity bits and the frame-pulse enable.

Top module: `lcd_timing_gen`

## Requirements
- R1: While reset is asserted, and on every clock after a clock edge that saw the display-on bit clear, both counters are 0 and frame_irq is 0. While display-on is clear, de is 0 and each sync output equals its polarity bit, which is its inactive level.
- R2: With display-on set, hcount advances by one on each clock where pix_en is high and holds otherwise. After HT-1 it returns to 0, where HT = (field+1)*8. vcount advances when hcount wraps and returns to 0 after VT-1, where VT = field+1.
- R3: de is high exactly when display-on is set, hcount < HD and vcount < VD. Here HD = (high byte of register 1 + 1)*8 and VD = (register 3 bits 11:0) + 1.
- R4: The unpolarised line sync is active while HS <= hcount < HS+HW. HS = (register 2 bits 11:0 + 1)*8 and HW = (register 2 bits 15:12 + 1)*8.
- R5: The unpolarised frame sync is active while VS <= vcount < VS+VW. VS = (register 5 bits 11:0) + 1 and VW = (register 5 bits 15:12) + 1.
- R6: Control bit 1 set makes hsync active-low. Control bit 2 set makes vsync active-low. With a bit clear, the matching output is active-high.
- R7: When control bit 3 is set, frame_irq is high for one clock right after the counters wrap from (HT-1, VT-1) to (0,0). When bit 3 is clear, frame_irq stays 0.
- R8: Writes to registers 1 to 5 change the running timing only at the frame wrap, or on any clock while display-on is clear.
- R9: The register map is as follows. wr_addr 0 is control: bit0 display-on, bit1 line polarity, bit2 frame polarity, bit3 frame-pulse enable. wr_addr 1 holds the horizontal total field in the low byte and the display-width field in the high byte. wr_addr 2 holds the line sync position and width. wr_addr 3 holds the display lines minus one. wr_addr 4 holds the total lines minus one. wr_addr 5 holds the frame sync start and width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel-clock enable; counters step when high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| hsync | output | 1 | Line sync, polarity applied |
| vsync | output | 1 | Frame sync, polarity applied |
| de | output | 1 | Display enable |
| hcount | output | 11 | Pixel position within the line |
| vcount | output | 12 | Line position within the frame |
| frame_irq | output | 1 | One-clock start-of-frame pulse |

## Verification
The assertions assume that the programmed horizontal total fits the 11-bit pixel counter. They also assume that the line sync position and width, and the frame sync start and width, fall inside the total they belong to. The bench programs only small frames that meet these limits. The pixel enable varies from always high to sparse pseudo-random pulses. Register writes happen both while the display is off and in the middle of a running frame, so the shadow-to-active transfer is exercised at the wrap.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [10:0]   hcount,
  output logic [11:0]   vcount,
  output logic          frame_irq
);
  localparam int HCW = 11;
  localparam int VCW = 12;

  logic [3:0]  ctrl;
  logic [15:0] sh_hc, sh_hs, sh_vs, ac_hc, ac_hs, ac_vs;
  logic [11:0] sh_vd, sh_vt, ac_vd, ac_vt;

  wire on   = ctrl[0];
  wire hpol = ctrl[1];
  wire vpol = ctrl[2];
  wire ien  = ctrl[3];

  wire [15:0] htot  = ({8'd0, ac_hc[7:0]}  + 16'd1) << 3;
  wire [15:0] hdisp = ({8'd0, ac_hc[15:8]} + 16'd1) << 3;
  wire [15:0] hsp   = ({4'd0, ac_hs[11:0]} + 16'd1) << 3;
  wire [15:0] hsw   = ({12'd0, ac_hs[15:12]} + 16'd1) << 3;
  wire [15:0] vtot  = {4'd0, ac_vt} + 16'd1;
  wire [15:0] vdisp = {4'd0, ac_vd} + 16'd1;
  wire [15:0] vsp   = {4'd0, ac_vs[11:0]} + 16'd1;
  wire [15:0] vsw   = {12'd0, ac_vs[15:12]} + 16'd1;

  wire [15:0] h16 = {{(16-HCW){1'b0}}, hcount};
  wire [15:0] v16 = {{(16-VCW){1'b0}}, vcount};

  wire hlast = (h16 == htot - 16'd1);
  wire vlast = (v16 == vtot - 16'd1);
  wire wrap  = hlast & vlast;
  wire load  = !on | (pix_en & wrap);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      sh_hc <= '0; sh_hs <= '0; sh_vs <= '0; sh_vd <= '0; sh_vt <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: ctrl  <= wr_data[3:0];
        3'd1: sh_hc <= wr_data;
        3'd2: sh_hs <= wr_data;
        3'd3: sh_vd <= wr_data[11:0];
        3'd4: sh_vt <= wr_data[11:0];
        3'd5: sh_vs <= wr_data;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ac_hc <= '0; ac_hs <= '0; ac_vs <= '0; ac_vd <= '0; ac_vt <= '0;
    end else if (load) begin
      ac_hc <= sh_hc; ac_hs <= sh_hs; ac_vs <= sh_vs;
      ac_vd <= sh_vd; ac_vt <= sh_vt;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hcount <= '0;
      vcount <= '0;
    end else if (!on) begin
      hcount <= '0;
      vcount <= '0;
    end else if (pix_en) begin
      if (hlast) begin
        hcount <= '0;
        vcount <= vlast ? '0 : vcount + 1'b1;
      end else begin
        hcount <= hcount + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) frame_irq <= 1'b0;
    else        frame_irq <= on & ien & pix_en & wrap;

  wire h_act = on & (h16 >= hsp) & (h16 < hsp + hsw);
  wire v_act = on & (v16 >= vsp) & (v16 < vsp + vsw);

  assign hsync = h_act ^ hpol;
  assign vsync = v_act ^ vpol;
  assign de    = on & (h16 < hdisp) & (v16 < vdisp);

  p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> (hcount == '0 && vcount == '0 && !frame_irq));

  p_hcount_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h16 < htot);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !pix_en) |=> ($stable(hcount) && $stable(vcount)));

  p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (on && pix_en && hlast && !vlast) |=> (vcount == $past(vcount) + 1'b1));

  p_irq_at_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_irq |-> (hcount == '0 && vcount == '0));

  p_param_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (on && !(pix_en && wrap)) |=> ($stable(ac_hc) && $stable(ac_vt)));
endmodule

// File: tb/lcd_timing_gen_tb_top.sv
`timescale 1ns/100ps
module lcd_timing_gen_tb_top;
  logic clk = 0, rst_n = 0, pix_en = 1, wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [15:0] wr_data = 0;
  logic hsync, vsync, de, frame_irq;
  logic [10:0] hcount;
  logic [11:0] vcount;

  int checks = 0, failures = 0;
  bit done = 0;
  int pix_mode = 0;

  always #2.5 clk = ~clk;

  lcd_timing_gen dut_i (.clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
    .hcount(hcount), .vcount(vcount), .frame_irq(frame_irq));

  // behavioural reference
  int m_ctrl, m_sh[6], m_ac[6], mh, mv, mirq;
  int t_htot, t_vtot, t_on, t_wrap, t_irq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; mh = 0; mv = 0; mirq = 0;
      for (int i = 0; i < 6; i++) begin m_sh[i] = 0; m_ac[i] = 0; end
    end else begin
      t_htot = ((m_ac[1] & 255) + 1) * 8;
      t_vtot = (m_ac[4] & 4095) + 1;
      t_on   = m_ctrl & 1;
      t_wrap = (mh == t_htot - 1) && (mv == t_vtot - 1);
      t_irq  = t_on && pix_en && ((m_ctrl >> 3) & 1) && t_wrap;
      if (!t_on) begin mh = 0; mv = 0; end
      else if (pix_en) begin
        if (mh == t_htot - 1) begin mh = 0; mv = (mv == t_vtot - 1) ? 0 : mv + 1; end
        else mh = mh + 1;
      end
      if (!t_on || (pix_en && t_wrap))
        for (int i = 0; i < 6; i++) m_ac[i] = m_sh[i];
      if (wr_en) begin
        if (wr_addr == 0) m_ctrl = int'(wr_data) & 15;
        else if (wr_addr <= 5) m_sh[wr_addr] = int'(wr_data);
      end
      mirq = t_irq;
    end
  end

  int e_hd, e_vd, e_hsp, e_hsw, e_vsp, e_vsw, e_on, e_de, e_hs, e_vs;
  always @(negedge clk) if (rst_n && !done) begin
    e_on  = m_ctrl & 1;
    e_hd  = ((m_ac[1] >> 8) + 1) * 8;
    e_vd  = (m_ac[3] & 4095) + 1;
    e_hsp = ((m_ac[2] & 4095) + 1) * 8;
    e_hsw = ((m_ac[2] >> 12) + 1) * 8;
    e_vsp = (m_ac[5] & 4095) + 1;
    e_vsw = (m_ac[5] >> 12) + 1;
    e_de  = e_on && mh < e_hd && mv < e_vd;
    e_hs  = (e_on && mh >= e_hsp && mh < e_hsp + e_hsw) ^ ((m_ctrl >> 1) & 1);
    e_vs  = (e_on && mv >= e_vsp && mv < e_vsp + e_vsw) ^ ((m_ctrl >> 2) & 1);
    checks++;
    if (int'(hcount) != mh || int'(vcount) != mv) begin
      failures++;
      $display("FAIL R2 R9 counters h=%0d v=%0d expected h=%0d v=%0d", hcount, vcount, mh, mv);
    end
    if (int'(de) != e_de) begin
      failures++; $display("FAIL R3 de=%0d expected %0d", de, e_de);
    end
    if (int'(hsync) != e_hs) begin
      failures++; $display("FAIL R4 R6 hsync=%0d expected %0d", hsync, e_hs);
    end
    if (int'(vsync) != e_vs) begin
      failures++; $display("FAIL R5 R6 vsync=%0d expected %0d", vsync, e_vs);
    end
    if (int'(frame_irq) != mirq) begin
      failures++; $display("FAIL R7 frame_irq=%0d expected %0d", frame_irq, mirq);
    end
  end

  always @(negedge clk) pix_en <= (pix_mode == 0) ? 1'b1 : ($urandom % 3 == 0);

  task automatic wreg(input int a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = 3'(a); wr_data = 16'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int cnt, mx;
  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {hsync, vsync, de, frame_irq}, 0);
    chk("R1 reset hcount", hcount, 0);
    chk("R1 reset vcount", vcount, 0);
    rst_n = 1;
    // config 1: HT=16 HD=8, hsync 8..15, VD=2 VT=4, vsync line 2
    wreg(1, 16'h0001); wreg(2, 16'h0000); wreg(3, 1); wreg(4, 3); wreg(5, 16'h0001);
    wreg(0, 6);
    @(negedge clk);
    chk("R6 idle hsync high", hsync, 1);
    chk("R6 idle vsync high", vsync, 1);
    chk("R1 idle de", de, 0);
    wreg(0, 0);
    wreg(0, 1);
    cnt = 0;
    repeat (3 * 64 + 5) begin @(negedge clk); cnt += frame_irq; end
    chk("R7 no pulse when disabled", cnt, 0);
    wreg(0, 0);
    wreg(0, 9);
    cnt = 0;
    repeat (3 * 64 + 5) begin @(negedge clk); cnt += frame_irq; end
    chk("R7 pulses in three frames", cnt, 3);
    wreg(0, 0);
    @(negedge clk);
    chk("R1 off hcount", hcount, 0);
    chk("R1 off vcount", vcount, 0);
    wreg(0, 1);
    repeat (8) @(negedge clk);
    wreg(1, 16'h0103);
    mx = 0;
    repeat (30) begin @(negedge clk); if (hcount > mx) mx = hcount; end
    chk("R8 old total kept mid-frame", mx, 15);
    repeat (30) @(negedge clk);
    mx = 0;
    repeat (40) begin @(negedge clk); if (hcount > mx) mx = hcount; end
    chk("R8 new total after wrap", mx, 31);
    // config 2 written mid-frame, sparse pixel enable, both polarities
    wreg(2, 16'h0002); wreg(3, 3); wreg(4, 5); wreg(5, 16'h1003);
    wreg(0, 15);
    pix_mode = 1;
    repeat (3000) @(negedge clk);
    pix_mode = 0;
    wreg(0, 13);
    repeat (400) @(negedge clk);
    finish_run();
  end
endmodule